// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block sits beside a small in-order core and checks every committed instruction against a permission policy that is fixed at boot. For each instruction it receives the program counter, a flag marking a memory access, the load/store direction and the data address. Two range selectors classify the program counter into a code region and the data address into a data region. Each region has an arbitrary start and an exclusive end, with no alignment or size rule. A permission matrix indexed by the executing code region then decides whether the access is allowed.

Control flow is policed as well. The checker remembers the code region of the previous instruction and requires an execute grant for every move from that region to the current one, including a move that stays inside one region. Any disallowed access produces a one-cycle violation report, registered one cycle after the access. The report carries the cause, the program counter and the data address. The checker only observes the core and never stalls it.

Boundaries and matrix rows are written through a small write-only register port during boot. Writing the lock register freezes the configuration. After that, every write is dropped and flagged as an error.

Top module: `region_access_checker`

## Requirements
- R1: A program counter maps to the lowest-numbered code region `i` with start[i] <= pc < end[i]. When several regions overlap, the lowest index wins.
- R2: A data address maps to the lowest-numbered data region by the same inclusive-start, exclusive-end rule. Boundaries may be any byte address.
- R3: A load (`accMem`=1, `accStore`=0) needs the read bit, and a store (`accStore`=1) needs the write bit. Both bits come from the data-matrix row of the current code region. For target region t, the read bit is bit 3t of the row and the write bit is bit 3t+1.
- R4: Every valid instruction after the first one since reset needs the execute bit of the transition from the previous code region to the current one. This is bit 3t+2 of the code-matrix row of the previous region, where t is the current region. The first instruction after reset has no transition check.
- R5: An address that matches no region gets the "none" index. Any check that uses a "none" index is denied.
- R6: On the clock edge that samples a valid access, `violValid` is set only if a check fails. In that case `violCause` bit 0 flags a denied transition and bit 1 flags a denied data access, and `violPc` and `violAddr` hold that access's pc and address. Allowed accesses leave `violValid` at 0.
- R7: Register map: `cfgAddr[5:4]` = 0 selects a code boundary, 1 a data boundary, 2 a matrix row, 3 the lock. For a boundary, `[3:1]` is the region and `[0]` picks start (0) or end (1). For a matrix row, `[3]` picks the data matrix (0) or the code matrix (1) and `[2:0]` is the source code region; bits 3t..3t+2 of the data word are the entry for target t. Writes before the lock take effect and never raise `cfgErr`.
- R8: Writing 1 in bit 0 of the lock register sets the lock for good. Every later write is ignored and pulses `cfgErr` on the following cycle.
- R9: After reset, all boundaries and grants are zero, so every address is "none". `violValid` and `cfgErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A committed instruction is presented this cycle |
| accPc | input | ADDR_W | Program counter of the instruction |
| accMem | input | 1 | Instruction performs a data access |
| accStore | input | 1 | Data access is a store (else a load) |
| accAddr | input | ADDR_W | Data address of the access |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration register address |
| cfgWrData | input | ADDR_W | Configuration write data |
| cfgErr | output | 1 | Previous-cycle write was rejected by the lock |
| violValid | output | 1 | Previous-cycle access broke the policy |
| violCause | output | 2 | bit0 transition denied, bit1 data access denied |
| violPc | output | ADDR_W | Program counter of the offending access |
| violAddr | output | ADDR_W | Data address of the offending access |

## Verification
The case that is hardest to reach is a transition check whose outcome depends on the previous instruction's region. This includes transitions out of or into the "none" index and into regions that overlap. The stimulus walks the program counter across region edges one byte apart, in an order chosen so that consecutive instructions hit granted, missing and unmapped transitions, while the data side alternates loads and stores on boundary addresses. The sequence then locks the block and repeats accesses after rejected rewrites, so the ignored writes show up at the violation port.

// File: rtl/rac_pkg.sv
package rac_pkg;
  // Configuration register groups, decoded from the top address bits.
  typedef enum logic [1:0] {
    SEL_CODE_BND = 2'd0,
    SEL_DATA_BND = 2'd1,
    SEL_PERM     = 2'd2,
    SEL_LOCK     = 2'd3
  } cfgSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic bndWr;
    logic bndIsData;
    logic bndIsEnd;
    logic permWr;
    logic permIsCode;
  } racStrobe_t;

  // Bit positions inside one 3-bit matrix entry.
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
endpackage

// File: rtl/rac_range_sel.sv
module rac_range_sel #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NREG-1:0][ADDR_W-1:0]  starts,
  input  logic [NREG-1:0][ADDR_W-1:0]  ends,
  output logic [IDX_W-1:0]             idx
);
  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NREG);

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = (addr >= starts[g]) && (addr < ends[g]);
  end

  // Lowest index wins: scan from the top down so the last match is the lowest.
  always_comb begin
    idx = NONE_IDX;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rac_ctrl.sv
module rac_ctrl
  import rac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic       cfgEndBit,
  input  logic       cfgClassBit,
  input  logic       cfgLockBit,
  output racStrobe_t strobe,
  output logic       cfgLocked,
  output logic       cfgErr
);
  logic writeOk;

  assign writeOk = cfgWrEn && !cfgLocked;

  always_comb begin
    strobe = '0;
    if (writeOk) begin
      unique case (cfgSel_e'(cfgSel))
        SEL_CODE_BND: begin
          strobe.bndWr    = 1'b1;
          strobe.bndIsEnd = cfgEndBit;
        end
        SEL_DATA_BND: begin
          strobe.bndWr     = 1'b1;
          strobe.bndIsData = 1'b1;
          strobe.bndIsEnd  = cfgEndBit;
        end
        SEL_PERM: begin
          strobe.permWr     = 1'b1;
          strobe.permIsCode = cfgClassBit;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLocked <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      if (writeOk && cfgSel_e'(cfgSel) == SEL_LOCK && cfgLockBit) cfgLocked <= 1'b1;
      cfgErr <= cfgWrEn && cfgLocked;
    end
  end
endmodule

// File: rtl/rac_datapath.sv
module rac_datapath
  import rac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8,
  parameter int RIDX_W = 3,
  parameter int IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  racStrobe_t           strobe,
  input  logic [RIDX_W-1:0]    cfgIdx,
  input  logic [ADDR_W-1:0]    cfgWrData,
  input  logic                 accValid,
  input  logic [ADDR_W-1:0]    accPc,
  input  logic                 accMem,
  input  logic                 accStore,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic                 violValid,
  output logic [1:0]           violCause,
  output logic [ADDR_W-1:0]    violPc,
  output logic [ADDR_W-1:0]    violAddr
);
  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NREG);

  logic [NREG-1:0][ADDR_W-1:0] codeStart, codeEnd, dataStart, dataEnd;
  logic [2:0] permData [NREG][NREG];
  logic [2:0] permCode [NREG][NREG];

  logic [IDX_W-1:0] curCode, curData, prevCode;
  logic             prevValid;
  logic             xferDeny, dataDeny;
  logic [2:0]       xferEntry, dataEntry;

  // Configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeStart <= '0;
      codeEnd   <= '0;
      dataStart <= '0;
      dataEnd   <= '0;
      for (int s = 0; s < NREG; s++) begin
        for (int t = 0; t < NREG; t++) begin
          permData[s][t] <= '0;
          permCode[s][t] <= '0;
        end
      end
    end else begin
      if (strobe.bndWr) begin
        unique case ({strobe.bndIsData, strobe.bndIsEnd})
          2'b00: codeStart[cfgIdx] <= cfgWrData;
          2'b01: codeEnd[cfgIdx]   <= cfgWrData;
          2'b10: dataStart[cfgIdx] <= cfgWrData;
          default: dataEnd[cfgIdx] <= cfgWrData;
        endcase
      end
      if (strobe.permWr) begin
        for (int t = 0; t < NREG; t++) begin
          if (strobe.permIsCode) permCode[cfgIdx][t] <= cfgWrData[3*t +: 3];
          else                   permData[cfgIdx][t] <= cfgWrData[3*t +: 3];
        end
      end
    end
  end

  rac_range_sel #(.ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W)) codeSel_i (
    .addr(accPc), .starts(codeStart), .ends(codeEnd), .idx(curCode));

  rac_range_sel #(.ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W)) dataSel_i (
    .addr(accAddr), .starts(dataStart), .ends(dataEnd), .idx(curData));

  // The MSB of an index is set only for the "none" value (NREG is a power of two).
  assign xferEntry = permCode[prevCode[RIDX_W-1:0]][curCode[RIDX_W-1:0]];
  assign dataEntry = permData[curCode[RIDX_W-1:0]][curData[RIDX_W-1:0]];

  always_comb begin
    xferDeny = prevValid &&
               (prevCode[IDX_W-1] || curCode[IDX_W-1] || !xferEntry[PERM_X]);
    dataDeny = accMem &&
               (curCode[IDX_W-1] || curData[IDX_W-1] ||
                !(accStore ? dataEntry[PERM_W] : dataEntry[PERM_R]));
  end

  // Transition history and registered violation report
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCode  <= NONE_IDX;
      prevValid <= 1'b0;
      violValid <= 1'b0;
      violCause <= '0;
      violPc    <= '0;
      violAddr  <= '0;
    end else begin
      violValid <= accValid && (xferDeny || dataDeny);
      if (accValid) begin
        prevCode  <= curCode;
        prevValid <= 1'b1;
        if (xferDeny || dataDeny) begin
          violCause <= {dataDeny, xferDeny};
          violPc    <= accPc;
          violAddr  <= accAddr;
        end
      end
    end
  end
endmodule

// File: rtl/region_access_checker.sv
module region_access_checker
  import rac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8,
  localparam int RIDX_W = $clog2(NREG),
  localparam int IDX_W  = RIDX_W + 1,
  localparam int CFG_AW = RIDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accPc,
  input  logic              accMem,
  input  logic              accStore,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic              cfgErr,
  output logic              violValid,
  output logic [1:0]        violCause,
  output logic [ADDR_W-1:0] violPc,
  output logic [ADDR_W-1:0] violAddr
);
  racStrobe_t        strobe;
  logic              cfgLocked;
  logic [RIDX_W-1:0] cfgIdx;

  // Boundary writes take the region from [RIDX_W:1]; matrix rows from [RIDX_W-1:0].
  assign cfgIdx = strobe.bndWr ? cfgAddr[RIDX_W:1] : cfgAddr[RIDX_W-1:0];

  rac_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgAddr[CFG_AW-1 -: 2]),
    .cfgEndBit  (cfgAddr[0]),
    .cfgClassBit(cfgAddr[RIDX_W]),
    .cfgLockBit (cfgWrData[0]),
    .strobe     (strobe),
    .cfgLocked  (cfgLocked),
    .cfgErr     (cfgErr)
  );

  rac_datapath #(.ADDR_W(ADDR_W), .NREG(NREG), .RIDX_W(RIDX_W), .IDX_W(IDX_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgIdx   (cfgIdx),
    .cfgWrData(cfgWrData),
    .accValid (accValid),
    .accPc    (accPc),
    .accMem   (accMem),
    .accStore (accStore),
    .accAddr  (accAddr),
    .violValid(violValid),
    .violCause(violCause),
    .violPc   (violPc),
    .violAddr (violAddr)
  );
endmodule

// File: rtl/rac_checker.sv
module rac_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [ADDR_W-1:0] accPc,
  input logic              accMem,
  input logic [ADDR_W-1:0] accAddr,
  input logic              cfgWrEn,
  input logic              cfgLocked,
  input logic              cfgErr,
  input logic              violValid,
  input logic [1:0]        violCause,
  input logic [ADDR_W-1:0] violPc,
  input logic [ADDR_W-1:0] violAddr
);
  AST_VIOL_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> $past(accValid)); // R6

  AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> violCause != 2'b00); // R6

  AST_VIOL_REPORTS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> (violPc == $past(accPc)) && (violAddr == $past(accAddr))); // R6

  AST_DATA_CAUSE_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (violValid && violCause[1]) |-> $past(accMem)); // R3

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgLocked |=> cfgLocked); // R8

  AST_LOCKED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgLocked) |=> cfgErr); // R8

  AST_ERR_ONLY_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> ($past(cfgWrEn) && $past(cfgLocked))); // R7
endmodule

bind region_access_checker rac_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accPc    (accPc),
  .accMem   (accMem),
  .accAddr  (accAddr),
  .cfgWrEn  (cfgWrEn),
  .cfgLocked(cfgLocked),
  .cfgErr   (cfgErr),
  .violValid(violValid),
  .violCause(violCause),
  .violPc   (violPc),
  .violAddr (violAddr)
);

// File: tb/region_access_checker_tb.sv
`timescale 1ns/1ps
module region_access_checker_tb_top;
  localparam int AW = 32;
  localparam int NR = 8;
  localparam int CAW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          accValid = 1'b0;
  logic [AW-1:0] accPc = '0;
  logic          accMem = 1'b0;
  logic          accStore = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic          cfgWrEn = 1'b0;
  logic [CAW-1:0] cfgAddr = '0;
  logic [AW-1:0] cfgWrData = '0;
  logic          cfgErr;
  logic          violValid;
  logic [1:0]    violCause;
  logic [AW-1:0] violPc;
  logic [AW-1:0] violAddr;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk; // 125 MHz

  region_access_checker #(.ADDR_W(AW), .NREG(NR)) dut_i (.*);

  // Reference model
  logic [AW-1:0] mCS [NR], mCE [NR], mDS [NR], mDE [NR];
  logic [2:0]    mPD [NR][NR], mPC [NR][NR];
  logic          mLocked = 1'b0;
  int            mPrev = NR;
  logic          mPrevValid = 1'b0;

  typedef struct {
    logic [1:0]    cause;
    logic [AW-1:0] pc;
    logic [AW-1:0] addr;
    string         req;
  } expItem_t;
  expItem_t expQ [$];

  function automatic int classify(logic [AW-1:0] a, logic isData);
    for (int i = 0; i < NR; i++) begin
      if (isData ? (a >= mDS[i] && a < mDE[i]) : (a >= mCS[i] && a < mCE[i])) return i;
    end
    return NR;
  endfunction

  task automatic check(logic ok, string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [CAW-1:0] a, logic [AW-1:0] d, string req);
    logic expErr;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    expErr = mLocked;
    if (!mLocked) begin
      case (a[5:4])
        2'd0: if (a[0]) mCE[a[3:1]] = d; else mCS[a[3:1]] = d;
        2'd1: if (a[0]) mDE[a[3:1]] = d; else mDS[a[3:1]] = d;
        2'd2: for (int t = 0; t < NR; t++) begin
                if (a[3]) mPC[a[2:0]][t] = d[3*t +: 3];
                else      mPD[a[2:0]][t] = d[3*t +: 3];
              end
        default: if (d[0]) mLocked = 1'b1;
      endcase
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
    check(cfgErr === expErr, req, "cfgErr", AW'(cfgErr), AW'(expErr));
  endtask

  task automatic access(logic [AW-1:0] pc, logic mem, logic st, logic [AW-1:0] ad, string req);
    expItem_t it;
    int c, d;
    logic [2:0] e;
    @(negedge clk);
    accValid = 1'b1; accPc = pc; accMem = mem; accStore = st; accAddr = ad;
    c = classify(pc, 1'b0);
    d = classify(ad, 1'b1);
    it.cause = 2'b00;
    if (mPrevValid && (mPrev >= NR || c >= NR || !mPC[mPrev][c][2])) it.cause[0] = 1'b1;
    if (mem) begin
      if (c >= NR || d >= NR) it.cause[1] = 1'b1;
      else begin
        e = mPD[c][d];
        if (!(st ? e[1] : e[0])) it.cause[1] = 1'b1;
      end
    end
    mPrev = c;
    mPrevValid = 1'b1;
    it.pc = pc; it.addr = ad; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0;
  endtask

  // Scoreboard monitor: one expected item per sampled access.
  always @(posedge clk) begin
    expItem_t it;
    #2;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      check(violValid === (it.cause != 2'b00), it.req, "violValid", AW'(violValid), AW'(it.cause != 2'b00));
      if (it.cause != 2'b00) begin
        check(violCause === it.cause, it.req, "violCause", AW'(violCause), AW'(it.cause));
        check(violPc === it.pc, "R6", "violPc", violPc, it.pc);
        check(violAddr === it.addr, "R6", "violAddr", violAddr, it.addr);
      end
    end
  end

  initial begin
    #(8 * 200000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      mCS[i] = '0; mCE[i] = '0; mDS[i] = '0; mDE[i] = '0;
      for (int t = 0; t < NR; t++) begin mPD[i][t] = '0; mPC[i][t] = '0; end
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(violValid === 1'b0, "R9", "violValid after reset", AW'(violValid), '0);
    check(cfgErr === 1'b0, "R9", "cfgErr after reset", AW'(cfgErr), '0);

    // R9/R5: unconfigured, everything maps to none
    access(32'h0000_1000, 1'b1, 1'b0, 32'h8000_0000, "R9");
    access(32'h0000_1000, 1'b0, 1'b0, 32'h0, "R5");
    idle();

    // R7: boot configuration at odd, overlapping boundaries
    cfgWrite(6'h00, 32'h0000_1000, "R7"); cfgWrite(6'h01, 32'h0000_1003, "R7");
    cfgWrite(6'h02, 32'h0000_1000, "R7"); cfgWrite(6'h03, 32'h0000_2000, "R7");
    cfgWrite(6'h04, 32'h0000_3000, "R7"); cfgWrite(6'h05, 32'h0000_3100, "R7");
    cfgWrite(6'h10, 32'h8000_0001, "R7"); cfgWrite(6'h11, 32'h8000_0101, "R7");
    cfgWrite(6'h12, 32'h8000_0000, "R7"); cfgWrite(6'h13, 32'h9000_0000, "R7");
    cfgWrite(6'h28, 32'h0000_0024, "R7"); // code row 0: X to 0,1
    cfgWrite(6'h29, 32'h0000_0120, "R7"); // code row 1: X to 1,2
    cfgWrite(6'h2A, 32'h0000_0104, "R7"); // code row 2: X to 0,2
    cfgWrite(6'h20, 32'h0000_0019, "R7"); // data row 0: R to 0, RW to 1
    cfgWrite(6'h21, 32'h0000_0008, "R7"); // data row 1: R to 1
    cfgWrite(6'h30, 32'h0000_0000, "R8"); // lock bit clear: no lock

    access(32'h0000_1001, 1'b1, 1'b0, 32'h8000_0001, "R5");
    access(32'h0000_1002, 1'b1, 1'b1, 32'h8000_0001, "R3");
    access(32'h0000_1003, 1'b1, 1'b0, 32'h8000_0000, "R1");
    access(32'h0000_1FFF, 1'b0, 1'b0, 32'h0, "R4");
    access(32'h0000_2000, 1'b0, 1'b0, 32'h0, "R5");
    access(32'h0000_3000, 1'b0, 1'b0, 32'h0, "R5");
    access(32'h0000_30FF, 1'b1, 1'b0, 32'h8000_0100, "R3");
    access(32'h0000_1000, 1'b1, 1'b1, 32'h8000_0101, "R2");
    access(32'h0000_3000, 1'b0, 1'b0, 32'h0, "R4");
    access(32'h0000_1005, 1'b1, 1'b0, 32'h9000_0000, "R2");
    access(32'h0000_1005, 1'b1, 1'b1, 32'h8000_0000, "R3");
    access(32'h0000_1004, 1'b1, 1'b0, 32'h8000_0000, "R6");
    idle();

    // R8: lock, then attempted rewrites must be dropped
    cfgWrite(6'h30, 32'h0000_0001, "R8");
    cfgWrite(6'h21, 32'h00FF_FFFF, "R8");
    cfgWrite(6'h05, 32'h0000_0000, "R8");
    cfgWrite(6'h30, 32'h0000_0000, "R8");
    access(32'h0000_1005, 1'b1, 1'b1, 32'h8000_0000, "R8");
    access(32'h0000_3000, 1'b0, 1'b0, 32'h0, "R8");
    access(32'h0000_3000, 1'b0, 1'b0, 32'h0, "R8");
    idle();
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule